// File: doc/BRIEF.md
# Probabilistic Neighbour-Row Refresh Sampler

This block sits next to a DRAM controller's command scheduler and listens for row-close (precharge) events. Each close triggers one pseudo-random draw. When the draw falls under a programmable threshold, the block asks the scheduler for one extra activation of a row physically adjacent to the row just closed. A second random bit picks the row above or the row below. Repeated opening of one aggressor row therefore refreshes its victims now and then. The block keeps no per-row counters and no history.

Adjacency is worked out in physical row order. A programmable XOR mask turns the logical row into a physical row. The neighbour is found in physical space and then mapped back through the same mask. At the two ends of the row range the direction is forced inward, so the block never emits an address outside the range.

Requests go out through a valid/ready handshake. One request can wait at the output while a second waits behind it. Any further successful draws are dropped, and a saturating counter records them.

Top module: `nbr_refresh_sampler`

## Requirements
- R1: The random state is a 32-bit Galois LFSR. Each step shifts right by one and, when the bit shifted out was 1, XORs in 32'h80200003. The state advances by exactly one step on each cycle with `close_valid` high, and holds on every other cycle.
- R2: Reset and `seed_load` both load the state from `seed`. A seed of zero is replaced by 32'h00000001. `seed_load` takes priority over advancing.
- R3: A close is a hit when the low `THR_W` bits of the current state are below `threshold`, or when `threshold` is all ones. A threshold of zero never hits.
- R4: On a hit, bit 31 of the current state selects the direction: 1 selects physical row plus one, 0 selects physical row minus one.
- R5: The physical row is the logical row XOR `map_mask`. The emitted row is the chosen physical neighbour XOR `map_mask`.
- R6: When the physical row is 0 the neighbour is physical row 1. When the physical row is the last row (all ones) the neighbour is the last row minus one. Both cases ignore the direction bit.
- R7: A hit on a close at clock edge t makes `req_valid` high after edge t. A request that is not accepted keeps its bank and row unchanged.
- R8: At most two requests are held: the one at the output plus one queued. A request accepted on the same edge as a hit frees a place for it. A hit with no free place is dropped, and `drop_count` then increments, saturating at all ones.
- R9: After reset `req_valid` is low and `drop_count` is zero.
- R10: The request carries the bank of the close that caused it, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| close_valid | input | 1 | A row close happens this cycle |
| close_bank | input | BANK_W | Bank of the closed row |
| close_row | input | ROW_W | Logical row that was closed |
| threshold | input | THR_W | Hit threshold for the draw |
| map_mask | input | ROW_W | XOR mask between logical and physical row |
| seed | input | 32 | LFSR seed |
| seed_load | input | 1 | Reload the LFSR from `seed` |
| req_ready | input | 1 | Scheduler accepts the pending request |
| req_valid | output | 1 | Refresh request pending |
| req_bank | output | BANK_W | Bank of the request |
| req_row | output | ROW_W | Logical row to activate |
| drop_count | output | CNT_W | Saturating count of dropped hits |

## Verification
The hardest state to reach from the ports is a full buffer that receives further hits. It is reached by setting the threshold to all ones and holding `req_ready` low while closes arrive back to back, which forces drops. The next hardest is a close at an edge of the physical row range while the mask is nonzero. It is reached by driving closes whose logical row equals the mask, or the inverted mask. Reloading a zero seed and then issuing two closes with known outcomes pins down the draw and direction bits exactly. A behavioural model in the bench follows every cycle of the long random phases.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

    localparam int          LFSR_W    = 32;
    localparam logic [31:0] LFSR_MASK = 32'h80200003;
    localparam logic [31:0] SEED_SAFE = 32'h00000001;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } nbr_dir_e;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        logic [LFSR_W-1:0] sh;
        sh = s >> 1;
        return s[0] ? (sh ^ LFSR_MASK) : sh;
    endfunction

    function automatic logic [LFSR_W-1:0] seed_sanitize(input logic [LFSR_W-1:0] s);
        return (s == '0) ? SEED_SAFE : s;
    endfunction

endpackage

// File: rtl/nrs_lfsr.sv
module nrs_lfsr
    import nrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LFSR_W-1:0] seed,
    input  logic              seed_load,
    input  logic              advance,
    output logic [LFSR_W-1:0] state
);

    always_ff @(posedge clk) begin
        if (rst || seed_load)
            state <= seed_sanitize(seed);
        else if (advance)
            state <= lfsr_step(state);
    end

    assert_state_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    assert_hold_without_close_R1: assert property (@(posedge clk) disable iff (rst)
        (!advance && !seed_load) |=> $stable(state));

endmodule

// File: rtl/nrs_neighbour.sv
module nrs_neighbour
    import nrs_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic [ROW_W-1:0] row,
    input  logic [ROW_W-1:0] map_mask,
    input  nbr_dir_e         dir,
    output logic [ROW_W-1:0] nbr_row
);

    localparam logic [ROW_W-1:0] ROW_LAST = {ROW_W{1'b1}};

    logic [ROW_W-1:0] phys;
    logic [ROW_W-1:0] phys_nbr;

    always_comb begin
        phys = row ^ map_mask;
        if (phys == '0)
            phys_nbr = {{(ROW_W-1){1'b0}}, 1'b1};
        else if (phys == ROW_LAST)
            phys_nbr = ROW_LAST - 1'b1;
        else if (dir == DIR_UP)
            phys_nbr = phys + 1'b1;
        else
            phys_nbr = phys - 1'b1;
        nbr_row = phys_nbr ^ map_mask;
    end

endmodule

// File: rtl/nrs_req_buffer.sv
module nrs_req_buffer #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BANK_W-1:0] push_bank,
    input  logic [ROW_W-1:0]  push_row,
    input  logic              ready,
    output logic              valid,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [CNT_W-1:0]  drop_count
);

    localparam int DEPTH = 2;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
    } slot_t;

    slot_t      slots [DEPTH];
    logic [1:0] count;
    logic [1:0] count_left;
    logic       pop;
    logic       accept;
    slot_t      incoming;

    always_comb begin
        pop        = valid && ready;
        count_left = count - {1'b0, pop};
        accept     = push && (count_left < 2'(DEPTH));
        incoming   = '{bank: push_bank, row: push_row};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count      <= '0;
            drop_count <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else begin
            if (pop) slots[0] <= slots[1];
            if (accept) begin
                if (count_left == 2'd0) slots[0] <= incoming;
                else                    slots[1] <= incoming;
            end
            count <= count_left + {1'b0, accept};
            if (push && !accept && drop_count != CNT_MAX)
                drop_count <= drop_count + 1'b1;
        end
    end

    assign valid = (count != 2'd0);
    assign bank  = slots[0].bank;
    assign row   = slots[0].row;

    assert_hold_while_stalled_R7: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(bank) && $stable(row)));

    assert_drop_counts_R8: assert property (@(posedge clk) disable iff (rst)
        (push && valid && !ready && count == 2'd2 && drop_count != CNT_MAX)
        |=> drop_count == $past(drop_count) + 1'b1);

    assert_no_count_without_push_R8: assert property (@(posedge clk) disable iff (rst)
        !push |=> $stable(drop_count));

endmodule

// File: rtl/nbr_refresh_sampler.sv
module nbr_refresh_sampler
    import nrs_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int THR_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              close_valid,
    input  logic [BANK_W-1:0] close_bank,
    input  logic [ROW_W-1:0]  close_row,
    input  logic [THR_W-1:0]  threshold,
    input  logic [ROW_W-1:0]  map_mask,
    input  logic [31:0]       seed,
    input  logic              seed_load,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [BANK_W-1:0] req_bank,
    output logic [ROW_W-1:0]  req_row,
    output logic [CNT_W-1:0]  drop_count
);

    localparam int DIR_BIT = LFSR_W - 1;
    localparam logic [THR_W-1:0] THR_ALL = {THR_W{1'b1}};

    logic [LFSR_W-1:0] rnd;
    logic [THR_W-1:0]  draw;
    nbr_dir_e          dir;
    logic              hit;
    logic [ROW_W-1:0]  nbr_row;

    nrs_lfsr u_lfsr (
        .clk       (clk),
        .rst       (rst),
        .seed      (seed),
        .seed_load (seed_load),
        .advance   (close_valid),
        .state     (rnd)
    );

    generate
        if (THR_W < LFSR_W) begin : g_draw_narrow
            assign draw = rnd[THR_W-1:0];
        end else begin : g_draw_wide
            assign draw = THR_W'(rnd[DIR_BIT-1:0]);
        end
    endgenerate

    always_comb begin
        dir = nbr_dir_e'(rnd[DIR_BIT]);
        hit = close_valid && ((threshold == THR_ALL) || (draw < threshold));
    end

    nrs_neighbour #(.ROW_W(ROW_W)) u_nbr (
        .row      (close_row),
        .map_mask (map_mask),
        .dir      (dir),
        .nbr_row  (nbr_row)
    );

    nrs_req_buffer #(.BANK_W(BANK_W), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .push       (hit),
        .push_bank  (close_bank),
        .push_row   (nbr_row),
        .ready      (req_ready),
        .valid      (req_valid),
        .bank       (req_bank),
        .row        (req_row),
        .drop_count (drop_count)
    );

    logic [ROW_W-1:0] phys_close;
    logic [ROW_W-1:0] phys_nbr;
    assign phys_close = close_row ^ map_mask;
    assign phys_nbr   = nbr_row ^ map_mask;

    assert_zero_threshold_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (threshold == '0) |-> !hit);

    assert_adjacent_physical_R6: assert property (@(posedge clk) disable iff (rst)
        close_valid |-> ((phys_nbr == phys_close + 1'b1) || (phys_nbr == phys_close - 1'b1)));

    assert_request_after_hit_R7: assert property (@(posedge clk) disable iff (rst)
        hit |=> req_valid);

    assert_reset_clean_R9: assert property (@(posedge clk)
        $past(rst) |-> (!req_valid && drop_count == '0));

endmodule

// File: tb/tb_nbr_refresh_sampler.sv
module tb_nbr_refresh_sampler;

    localparam int BANK_W = 3;
    localparam int ROW_W  = 14;
    localparam int THR_W  = 16;
    localparam int CNT_W  = 16;
    localparam logic [ROW_W-1:0] LAST = {ROW_W{1'b1}};

    logic              clk = 1'b0;
    logic              rst;
    logic              close_valid;
    logic [BANK_W-1:0] close_bank;
    logic [ROW_W-1:0]  close_row;
    logic [THR_W-1:0]  threshold;
    logic [ROW_W-1:0]  map_mask;
    logic [31:0]       seed;
    logic              seed_load;
    logic              req_ready;
    logic              req_valid;
    logic [BANK_W-1:0] req_bank;
    logic [ROW_W-1:0]  req_row;
    logic [CNT_W-1:0]  drop_count;

    always #4 clk = ~clk;

    nbr_refresh_sampler #(.BANK_W(BANK_W), .ROW_W(ROW_W), .THR_W(THR_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .close_valid(close_valid), .close_bank(close_bank),
        .close_row(close_row), .threshold(threshold), .map_mask(map_mask),
        .seed(seed), .seed_load(seed_load), .req_ready(req_ready),
        .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row),
        .drop_count(drop_count)
    );

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // behavioural reference
    logic [31:0] m_lfsr;
    int          m_bank[$];
    int          m_row[$];
    int          m_drops;

    function automatic logic [31:0] ref_step(input logic [31:0] s);
        logic [31:0] r;
        r = {1'b0, s[31:1]};
        if (s[0]) r = r ^ 32'h80200003;
        return r;
    endfunction

    function automatic logic [ROW_W-1:0] ref_nbr(input logic [ROW_W-1:0] r,
                                                 input logic [ROW_W-1:0] m, input logic up);
        logic [ROW_W-1:0] p;
        p = r ^ m;
        if (p == 0)         p = 1;
        else if (p == LAST) p = LAST - 1;
        else if (up)        p = p + 1;
        else                p = p - 1;
        return p ^ m;
    endfunction

    task automatic model_update();
        logic [31:0] sd;
        sd = (seed == 0) ? 32'd1 : seed;
        if (rst) begin
            m_lfsr = sd; m_bank.delete(); m_row.delete(); m_drops = 0;
            return;
        end
        if (m_row.size() > 0 && req_ready) begin
            void'(m_bank.pop_front()); void'(m_row.pop_front());
        end
        if (close_valid && (threshold == 16'hFFFF || m_lfsr[15:0] < threshold)) begin
            if (m_row.size() < 2) begin
                m_bank.push_back(int'(close_bank));
                m_row.push_back(int'(ref_nbr(close_row, map_mask, m_lfsr[31])));
            end else if (m_drops != 65535) begin
                m_drops++;
            end
        end
        if (seed_load)        m_lfsr = sd;
        else if (close_valid) m_lfsr = ref_step(m_lfsr);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        check(req_valid == (m_row.size() > 0), "R7 valid", int'(req_valid), int'(m_row.size() > 0));
        if (m_row.size() > 0) begin
            check(int'(req_row) == m_row[0], "R5 row", int'(req_row), m_row[0]);
            check(int'(req_bank) == m_bank[0], "R10 bank", int'(req_bank), m_bank[0]);
        end
        check(int'(drop_count) == m_drops, "R8 drops", int'(drop_count), m_drops);
    endtask

    task automatic cyc(input bit cv, input int bk, input int rw, input bit rdy);
        close_valid = cv;
        close_bank  = BANK_W'(bk);
        close_row   = ROW_W'(rw);
        req_ready   = rdy;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seen;
        int d0;
        rst = 1'b1; close_valid = 0; close_bank = 0; close_row = 0;
        threshold = 0; map_mask = 0; seed = 32'hACE12345; seed_load = 0; req_ready = 0;
        @(negedge clk);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        rst = 1'b0;
        // R9 reset state
        check(!req_valid, "R9 valid", int'(req_valid), 0);
        check(drop_count == 0, "R9 drops", int'(drop_count), 0);

        // R3: zero threshold never requests
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            cyc(1, $urandom % 8, $urandom % 16384, 1);
            if (req_valid) seen++;
        end
        check(seen == 0, "R3 zero threshold", seen, 0);

        // R4 R1: quarter probability, random ready, idle gaps
        threshold = 16'h4000;
        for (int i = 0; i < 2000; i++)
            cyc(($urandom % 3) != 0, $urandom % 8, $urandom % 16384, ($urandom % 2) == 1);

        // R5: nonzero mapping mask
        map_mask = 14'h02A5;
        for (int i = 0; i < 1500; i++)
            cyc(($urandom % 2) == 1, $urandom % 8, $urandom % 16384, ($urandom % 4) != 0);

        // R8: saturate the buffer
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1);
        threshold = 16'hFFFF;
        d0 = int'(drop_count);
        for (int i = 0; i < 10; i++) cyc(1, i % 8, 100 + i, 0);
        check(int'(drop_count) == d0 + 8, "R8 drop total", int'(drop_count), d0 + 8);
        check(req_valid == 1'b1, "R8 still pending", int'(req_valid), 1);
        cyc(1, 5, 200, 1);
        check(int'(drop_count) == d0 + 8, "R8 pop frees place", int'(drop_count), d0 + 8);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1);
        check(!req_valid, "R8 drained", int'(req_valid), 0);

        // R6: boundaries, plain and masked
        map_mask = 0;
        cyc(1, 2, 0, 0);
        check(req_row == 1, "R6 row zero", int'(req_row), 1);
        cyc(0, 0, 0, 1);
        cyc(1, 3, int'(LAST), 0);
        check(req_row == LAST - 1, "R6 last row", int'(req_row), int'(LAST - 1));
        cyc(0, 0, 0, 1);
        map_mask = 14'h1234;
        cyc(1, 1, 14'h1234, 0);
        check(req_row == (14'h0001 ^ 14'h1234), "R6 masked zero", int'(req_row), int'(14'h0001 ^ 14'h1234));
        cyc(0, 0, 0, 1);
        cyc(1, 1, int'(~14'h1234), 0);
        check(req_row == ((LAST - 1) ^ 14'h1234), "R6 masked last", int'(req_row), int'((LAST - 1) ^ 14'h1234));
        cyc(0, 0, 0, 1);
        map_mask = 0;

        // R2: zero seed becomes 1 -> first draw goes down, second goes up
        seed = 0; seed_load = 1;
        cyc(0, 0, 0, 1);
        seed_load = 0;
        cyc(1, 6, 5, 0);
        check(req_row == 4, "R2 seed one down", int'(req_row), 4);
        check(req_bank == 6, "R10 bank", int'(req_bank), 6);
        cyc(0, 0, 0, 1);
        cyc(1, 7, 5, 0);
        check(req_row == 6, "R4 up after step", int'(req_row), 6);
        cyc(0, 0, 0, 1);

        // R7: hold while stalled
        cyc(1, 4, 300, 0);
        for (int i = 0; i < 5; i++) begin
            cyc(0, 0, 0, 0);
            check(req_valid && req_bank == 4, "R7 held", int'(req_bank), 4);
        end
        cyc(0, 0, 0, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule